// File: doc/BRIEF.md
# Saturating Doubling Dual Multiply Lane Unit

This block is a 128-bit vector datapath for signed fixed-point arithmetic. It splits each source vector into pairs of neighbouring elements and, for each pair, multiplies two element pairs. It then adds the two products, or subtracts the second from the first. The result is doubled and an optional rounding constant is added. The value is clamped to a signed range twice the element width, and the upper half is kept as the element result. Three element sizes are supported: 8, 16 and 32 bits. For 32-bit elements the arithmetic is done in 64 bits, and an overflow check follows each of three steps.

A request carries two source vectors, the previous destination vector, a size code, three operation flags and a per-byte write enable. The new destination vector comes out of a register one cycle after the request, with a one-cycle done pulse. Each pair writes exactly one destination element. The other element, and any byte whose write enable is low, keeps the value from the previous destination vector supplied with the request. A sticky flag records whether any written lane had to be clamped. It is cleared by a separate input.

Top module: `dual_mul_sat_unit`

## Requirements
- R1: With size code 00 (8-bit elements), the result is T = 2*(a*b ± c*d) + (round ? 128 : 0), computed exactly. T is clamped to [-32768, 32767], and the element receives bits [15:8] of the clamped value. A lane saturates when the clamp changes T.
- R2: With size code 01 (16-bit elements), the same rule applies with a rounding constant of 32768, a clamp range of [-2^31, 2^31-1], and bits [31:16] as the result.
- R3: With size code 10 (32-bit elements), the steps are P = a*b ± c*d, then Q = P + (round ? 2^30 : 0), then R = 2*Q, each wrapped to 64 bits. If none of the three steps overflows the signed 64-bit range, the element receives R[63:32]. If a step overflows, the lane saturates. It then outputs 0x7FFFFFFF when the wrapped value at the first overflowing step is negative, and 0x80000000 otherwise.
- R4: op_sub=1 subtracts the second product from the first. op_sub=0 adds the two products.
- R5: With op_exch=0, pair i uses a=n[2i], b=m[2i], c=n[2i+1], d=m[2i+1], and writes destination element 2i. Element 2i+1 keeps its value from dst_old.
- R6: With op_exch=1, pair i uses a=n[2i], b=m[2i+1], c=n[2i+1], d=m[2i], and writes destination element 2i+1. Element 2i keeps its value from dst_old.
- R7: byte_wen[k] gates byte k (bits 8k+7..8k) of the destination. A byte whose enable is low takes the byte of dst_old. A saturating lane whose written element has no enabled byte does not set the flag.
- R8: sat_flag is set by any counted lane saturation in a request and stays set until sat_clr. When sat_clr and a saturating request arrive in the same cycle, the flag ends up set.
- R9: dst_new and out_done update on the clock edge after in_valid. out_done is high for exactly the cycles that follow a valid request. dst_new holds its value when in_valid is low.
- R10: An active-low reset clears dst_new, out_done and sat_flag.
- R11: Size code 11 is reserved. A request with it returns dst_old unchanged and never sets sat_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| size | input | 2 | Element size code: 00 byte, 01 half, 10 word, 11 reserved |
| op_sub | input | 1 | 1 subtracts products, 0 adds them |
| op_exch | input | 1 | Exchanged pairing, writes odd elements |
| op_round | input | 1 | Add rounding constant |
| src_n | input | 128 | First source vector |
| src_m | input | 128 | Second source vector |
| dst_old | input | 128 | Previous destination vector |
| byte_wen | input | 16 | Per-byte write enable |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_done | output | 1 | Result valid pulse |
| dst_new | output | 128 | Registered destination vector |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that the control inputs in_valid, size, op_exch and sat_clr are always known while reset is released. They also assume that dst_old and byte_wen are meaningful in the cycle of a request, because the checks on preserved elements compare against their previous-cycle values. The bench drives every input from defined values on the falling clock edge and holds in_valid low while reset is applied. It sweeps six boundary values for each of the four operands, in all eight flag combinations and all three sizes. It then applies random vectors that include the reserved size code and random byte enables, and compares each result against arithmetic done in 72-bit signed integers.

// File: rtl/dmsu_pkg.sv
package dmsu_pkg;
  typedef enum logic [1:0] {
    ESZ_BYTE = 2'b00,
    ESZ_HALF = 2'b01,
    ESZ_WORD = 2'b10,
    ESZ_RSVD = 2'b11
  } esz_t;

  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/dmsu_pair.sv
module dmsu_pair #(
  parameter int EW       = 8,
  parameter bit STEPWISE = 1'b0
) (
  input  logic [EW-1:0] n_lo,
  input  logic [EW-1:0] n_hi,
  input  logic [EW-1:0] m_lo,
  input  logic [EW-1:0] m_hi,
  input  logic          sub,
  input  logic          exch,
  input  logic          rnd,
  output logic [EW-1:0] res,
  output logic          sat
);
  localparam int PW = 2 * EW;
  localparam logic [EW-1:0] EMAX = {1'b0, {(EW-1){1'b1}}};
  localparam logic [EW-1:0] EMIN = {1'b1, {(EW-1){1'b0}}};

  logic signed [EW-1:0] opa, opb, opc, opd;
  logic signed [PW-1:0] p1, p2;

  // operand routing: exchange swaps the m elements
  always_comb begin
    opa = n_lo;
    opc = n_hi;
    opb = exch ? m_hi : m_lo;
    opd = exch ? m_lo : m_hi;
    p1  = PW'(opa) * PW'(opb);
    p2  = PW'(opc) * PW'(opd);
  end

  if (!STEPWISE) begin : g_wide
    localparam int WW = PW + 3;
    localparam logic signed [WW-1:0] ONE  = WW'(1);
    localparam logic signed [WW-1:0] SMAX = (ONE <<< (PW-1)) - ONE;
    localparam logic signed [WW-1:0] SMIN = ~SMAX;
    localparam logic signed [WW-1:0] RC   = ONE <<< (EW-1);
    logic signed [WW-1:0] s, t;
    always_comb begin
      s = sub ? (WW'(p1) - WW'(p2)) : (WW'(p1) + WW'(p2));
      t = (s <<< 1) + (rnd ? RC : '0);
      if (t > SMAX) begin
        sat = 1'b1;
        res = EMAX;
      end else if (t < SMIN) begin
        sat = 1'b1;
        res = EMIN;
      end else begin
        sat = 1'b0;
        res = EW'(t >>> EW);
      end
    end
  end else begin : g_step
    localparam logic [PW-1:0] RC2 = PW'(1) << (EW-2);
    logic [PW-1:0] r1, r2, r3, pick;
    logic ov1, ov2, ov3;
    always_comb begin
      r1  = sub ? (p1 - p2) : (p1 + p2);
      ov1 = (sub ? (p1[PW-1] != p2[PW-1]) : (p1[PW-1] == p2[PW-1]))
            && (r1[PW-1] != p1[PW-1]);
      r2  = r1 + (rnd ? RC2 : '0);
      ov2 = rnd && !r1[PW-1] && r2[PW-1];
      r3  = r2 + r2;
      ov3 = r2[PW-1] != r3[PW-1];
      // value at the first step that overflowed
      if (ov1)      pick = r1;
      else if (ov2) pick = r2;
      else          pick = r3;
      sat = ov1 | ov2 | ov3;
      if (sat) res = pick[PW-1] ? EMAX : EMIN;
      else     res = EW'(pick >> EW);
    end
  end
endmodule

// File: rtl/dmsu_lanes.sv
module dmsu_lanes #(
  parameter int VW       = 128,
  parameter int EW       = 8,
  parameter bit STEPWISE = 1'b0
) (
  input  logic [VW-1:0]   src_n,
  input  logic [VW-1:0]   src_m,
  input  logic [VW/8-1:0] byte_wen,
  input  logic            op_sub,
  input  logic            op_exch,
  input  logic            op_round,
  output logic [VW-1:0]   upd_data,
  output logic [VW/8-1:0] upd_bytes,
  output logic            lane_sat
);
  localparam int NP  = VW / (2 * EW);
  localparam int BPE = EW / 8;

  logic [NP-1:0] sat_raw, sat_live;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic [EW-1:0]  r;
    logic [BPE-1:0] w_lo, w_hi;

    dmsu_pair #(.EW(EW), .STEPWISE(STEPWISE)) u_pair (
      .n_lo (src_n[2*p*EW +: EW]),
      .n_hi (src_n[(2*p+1)*EW +: EW]),
      .m_lo (src_m[2*p*EW +: EW]),
      .m_hi (src_m[(2*p+1)*EW +: EW]),
      .sub  (op_sub),
      .exch (op_exch),
      .rnd  (op_round),
      .res  (r),
      .sat  (sat_raw[p])
    );

    assign w_lo = byte_wen[2*p*BPE +: BPE];
    assign w_hi = byte_wen[(2*p+1)*BPE +: BPE];

    assign upd_data[2*p*EW +: EW]     = r;
    assign upd_data[(2*p+1)*EW +: EW] = r;
    assign upd_bytes[2*p*BPE +: BPE]     = op_exch ? '0 : w_lo;
    assign upd_bytes[(2*p+1)*BPE +: BPE] = op_exch ? w_hi : '0;
    assign sat_live[p] = sat_raw[p] & (op_exch ? (|w_hi) : (|w_lo));
  end

  assign lane_sat = |sat_live;
endmodule

// File: rtl/dual_mul_sat_unit.sv
module dual_mul_sat_unit
  import dmsu_pkg::*;
#(
  parameter int VEC_W         = 128,
  parameter bit WORD_STEPWISE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         size,
  input  logic               op_sub,
  input  logic               op_exch,
  input  logic               op_round,
  input  logic [VEC_W-1:0]   src_n,
  input  logic [VEC_W-1:0]   src_m,
  input  logic [VEC_W-1:0]   dst_old,
  input  logic [VEC_W/8-1:0] byte_wen,
  input  logic               sat_clr,
  output logic               out_done,
  output logic [VEC_W-1:0]   dst_new,
  output logic               sat_flag
);
  localparam int NB = VEC_W / 8;

  function automatic logic [VEC_W-1:0] alt_byte_mask(input bit odd);
    logic [VEC_W-1:0] v;
    for (int k = 0; k < NB; k++) v[8*k +: 8] = ((k % 2) == (odd ? 1 : 0)) ? 8'hFF : 8'h00;
    return v;
  endfunction

  localparam logic [VEC_W-1:0] ODD_BYTES  = alt_byte_mask(1'b1);
  localparam logic [VEC_W-1:0] EVEN_BYTES = alt_byte_mask(1'b0);

  esz_t esz;
  assign esz = esz_t'(size);

  logic [VEC_W-1:0] ln_data  [NUM_SIZES];
  logic [NB-1:0]    ln_bytes [NUM_SIZES];
  logic             ln_sat   [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    dmsu_lanes #(
      .VW       (VEC_W),
      .EW       (8 << g),
      .STEPWISE (WORD_STEPWISE && (g == NUM_SIZES - 1))
    ) u_lanes (
      .src_n     (src_n),
      .src_m     (src_m),
      .byte_wen  (byte_wen),
      .op_sub    (op_sub),
      .op_exch   (op_exch),
      .op_round  (op_round),
      .upd_data  (ln_data[g]),
      .upd_bytes (ln_bytes[g]),
      .lane_sat  (ln_sat[g])
    );
  end

  logic [VEC_W-1:0] sel_data, sel_bits, wen_bits_in, merged;
  logic [NB-1:0]    sel_bytes;
  logic             sel_sat;

  always_comb begin
    case (esz)
      ESZ_BYTE: begin sel_data = ln_data[0]; sel_bytes = ln_bytes[0]; sel_sat = ln_sat[0]; end
      ESZ_HALF: begin sel_data = ln_data[1]; sel_bytes = ln_bytes[1]; sel_sat = ln_sat[1]; end
      ESZ_WORD: begin sel_data = ln_data[2]; sel_bytes = ln_bytes[2]; sel_sat = ln_sat[2]; end
      default:  begin sel_data = '0;         sel_bytes = '0;          sel_sat = 1'b0;      end
    endcase
    for (int k = 0; k < NB; k++) begin
      sel_bits[8*k +: 8]    = {8{sel_bytes[k]}};
      wen_bits_in[8*k +: 8] = {8{byte_wen[k]}};
    end
    merged = (dst_old & ~sel_bits) | (sel_data & sel_bits);
  end

  // next state
  logic [VEC_W-1:0] dst_d, dst_q;
  logic             done_d, done_q, sat_d, sat_q;

  always_comb begin
    dst_d  = in_valid ? merged : dst_q;
    done_d = in_valid;
    sat_d  = (sat_q & ~sat_clr) | (in_valid & sel_sat);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q  <= '0;
      done_q <= 1'b0;
      sat_q  <= 1'b0;
    end else begin
      dst_q  <= dst_d;
      done_q <= done_d;
      sat_q  <= sat_d;
    end
  end

  assign dst_new  = dst_q;
  assign out_done = done_q;
  assign sat_flag = sat_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done);
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst_new));
  assert_masked_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((dst_new ^ $past(dst_old)) & ~$past(wen_bits_in)) == '0));
  assert_odd_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && esz == ESZ_BYTE && !op_exch) |=> (((dst_new ^ $past(dst_old)) & ODD_BYTES) == '0));
  assert_even_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && esz == ESZ_BYTE && op_exch) |=> (((dst_new ^ $past(dst_old)) & EVEN_BYTES) == '0));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !in_valid) |=> !sat_flag);
  assert_rsvd_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && esz == ESZ_RSVD) |=> (dst_new == $past(dst_old)));
  assert_rsvd_nosat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && esz == ESZ_RSVD && !sat_flag) |=> !sat_flag);
endmodule

// File: tb/dual_mul_sat_unit_test.sv
`timescale 1ns/1ps
module dual_mul_sat_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, op_sub, op_exch, op_round, sat_clr;
  logic [1:0]   size;
  logic [127:0] src_n, src_m, dst_old;
  logic [15:0]  byte_wen;
  logic         out_done, sat_flag;
  logic [127:0] dst_new;

  int vectors = 0;
  int miscompares = 0;
  bit exp_sat = 1'b0;
  logic [31:0] lfsr = 32'h1badf00d;

  always #2.5 clk = ~clk;

  dual_mul_sat_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size(size),
    .op_sub(op_sub), .op_exch(op_exch), .op_round(op_round),
    .src_n(src_n), .src_m(src_m), .dst_old(dst_old), .byte_wen(byte_wen),
    .sat_clr(sat_clr), .out_done(out_done), .dst_new(dst_new), .sat_flag(sat_flag)
  );

  function automatic logic [31:0] next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  function automatic logic [127:0] rand128();
    return {next_rand(), next_rand(), next_rand(), next_rand()};
  endfunction

  function automatic logic signed [71:0] elem(input logic [127:0] v, input int idx, input int ew);
    logic [127:0] x;
    logic signed [71:0] r;
    x = v >> (idx * ew);
    r = '0;
    for (int k = 0; k < 72; k++) r[k] = (k < ew) ? x[k] : x[ew-1];
    return r;
  endfunction

  // boundary operand values: min, min+1, -1, 0, 1, max
  function automatic logic [31:0] corner(input int ew, input int i);
    logic signed [71:0] one, v;
    one = 72'sd1;
    case (i)
      0: v = -(one <<< (ew-1));
      1: v = -(one <<< (ew-1)) + one;
      2: v = -one;
      3: v = '0;
      4: v = one;
      default: v = (one <<< (ew-1)) - one;
    endcase
    return v[31:0];
  endfunction

  function automatic logic [127:0] pattern(input int ew, input logic [31:0] ev, input logic [31:0] od);
    logic [127:0] v;
    for (int e = 0; e < 128 / ew; e++)
      for (int k = 0; k < ew; k++) v[e*ew + k] = (e % 2 == 1) ? od[k] : ev[k];
    return v;
  endfunction

  // arithmetic model of R1-R7 and R11
  function automatic void model(input int sz, input bit sb, input bit ex, input bit rd,
                                input logic [127:0] n, input logic [127:0] m,
                                input logic [127:0] old, input logic [15:0] w,
                                output logic [127:0] nd, output bit ls);
    logic signed [71:0] a, b, c, d, t, hi, lo, r, one;
    int ew, tgt;
    bit s, any;
    nd = old;
    ls = 1'b0;
    if (sz == 3) return;
    one = 72'sd1;
    ew = 8 << sz;
    for (int p = 0; p < 128 / (2 * ew); p++) begin
      a = elem(n, 2*p, ew);
      c = elem(n, 2*p+1, ew);
      b = ex ? elem(m, 2*p+1, ew) : elem(m, 2*p, ew);
      d = ex ? elem(m, 2*p, ew)   : elem(m, 2*p+1, ew);
      t = (sb ? (a*b - c*d) : (a*b + c*d)) * 2 + (rd ? (one <<< (ew-1)) : '0);
      hi = (one <<< (2*ew-1)) - one;
      lo = -(one <<< (2*ew-1));
      if (t > hi)      begin r = hi >>> ew; s = 1'b1; end
      else if (t < lo) begin r = lo >>> ew; s = 1'b1; end
      else             begin r = t >>> ew;  s = 1'b0; end
      tgt = ex ? 2*p+1 : 2*p;
      any = 1'b0;
      for (int k = 0; k < ew; k++) begin
        if (w[(tgt*ew + k) / 8]) begin
          nd[tgt*ew + k] = r[k];
          any = 1'b1;
        end
      end
      if (s && any) ls = 1'b1;
    end
  endfunction

  task automatic fail_line(input string req, input logic [127:0] act, input logic [127:0] exp);
    miscompares++;
    $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic apply(input int sz, input bit sb, input bit ex, input bit rd,
                       input logic [127:0] n, input logic [127:0] m,
                       input logic [127:0] old, input logic [15:0] w, input bit clr);
    logic [127:0] nd;
    bit ls;
    string req;
    model(sz, sb, ex, rd, n, m, old, w, nd, ls);
    case (sz)
      0: req = "R1 R4 R5 R6 R7";
      1: req = "R2 R4 R5 R6 R7";
      2: req = "R3 R4 R5 R6 R7";
      default: req = "R11";
    endcase
    @(negedge clk);
    in_valid = 1'b1; size = sz[1:0]; op_sub = sb; op_exch = ex; op_round = rd;
    src_n = n; src_m = m; dst_old = old; byte_wen = w; sat_clr = clr;
    @(negedge clk);
    exp_sat = (exp_sat & ~clr) | ls;
    vectors++;
    if (dst_new !== nd) fail_line(req, dst_new, nd);
    if (out_done !== 1'b1) fail_line("R9 done", {127'd0, out_done}, 128'd1);
    if (sat_flag !== exp_sat) fail_line("R8 R7 R11 sat", {127'd0, sat_flag}, {127'd0, exp_sat});
    in_valid = 1'b0; sat_clr = 1'b0;
  endtask

  initial begin
    logic [127:0] held;
    rst_n = 1'b0; in_valid = 1'b0; size = 2'b00; op_sub = 1'b0; op_exch = 1'b0;
    op_round = 1'b0; src_n = '0; src_m = '0; dst_old = '0; byte_wen = '0; sat_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    vectors++;
    if (dst_new !== '0 || out_done !== 1'b0 || sat_flag !== 1'b0)
      fail_line("R10 reset", {dst_new[125:0], out_done, sat_flag}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // boundary sweep: every size, every flag set, six values per operand
    for (int sz = 0; sz < 3; sz++)
      for (int mode = 0; mode < 8; mode++)
        for (int cb = 0; cb < 1296; cb++) begin
          int ew = 8 << sz;
          apply(sz, mode[0], mode[1], mode[2],
                pattern(ew, corner(ew, cb % 6), corner(ew, (cb / 36) % 6)),
                pattern(ew, corner(ew, (cb / 6) % 6), corner(ew, cb / 216)),
                rand128(), 16'hFFFF, (cb % 97) == 0);
        end

    // random vectors with random enables and the reserved size code (R7, R11)
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ctl = next_rand();
      apply(ctl[1:0], ctl[2], ctl[3], ctl[4], rand128(), rand128(), rand128(),
            (ctl[7:5] == 0) ? 16'h0000 : next_rand()[15:0], ctl[12:8] == 0);
    end

    // R9 hold while idle
    apply(0, 1'b0, 1'b0, 1'b1, rand128(), rand128(), rand128(), 16'hFFFF, 1'b0);
    held = dst_new;
    repeat (3) @(negedge clk);
    vectors++;
    if (dst_new !== held) fail_line("R9 hold", dst_new, held);
    if (out_done !== 1'b0) fail_line("R9 idle done", {127'd0, out_done}, 128'd0);

    // R8 set by a saturating request, then clear alone
    apply(1, 1'b0, 1'b0, 1'b0, pattern(16, 32'h8000, 32'h8000), pattern(16, 32'h8000, 32'h8000),
          '0, 16'hFFFF, 1'b0);
    @(negedge clk); sat_clr = 1'b1; @(negedge clk); sat_clr = 1'b0; exp_sat = 1'b0;
    vectors++;
    if (sat_flag !== 1'b0) fail_line("R8 clear", {127'd0, sat_flag}, 128'd0);
    // R8 clear and saturating request together: flag ends set
    apply(0, 1'b0, 1'b0, 1'b0, pattern(8, 32'h80, 32'h80), pattern(8, 32'h80, 32'h80),
          '0, 16'hFFFF, 1'b1);
    // R7 saturating lane with no enabled byte leaves flag clear
    @(negedge clk); sat_clr = 1'b1; @(negedge clk); sat_clr = 1'b0; exp_sat = 1'b0;
    apply(2, 1'b0, 1'b0, 1'b0, pattern(32, 32'h80000000, 32'h80000000),
          pattern(32, 32'h80000000, 32'h80000000), rand128(), 16'hF0F0, 1'b0);

    // R10 reset during operation
    @(negedge clk); rst_n = 1'b0; @(negedge clk);
    vectors++;
    if (dst_new !== '0 || sat_flag !== 1'b0)
      fail_line("R10 mid reset", {dst_new[126:0], sat_flag}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule